// File: doc/BRIEF.md
# Full-Speed Serial Receive Byte Framer

This block sits behind a full-speed clock recovery stage and turns the recovered line into bytes. The recovery stage raises `bit_stb` for one cycle of the fast system clock each time a new line bit is ready. On that cycle the block samples the two single-ended line levels `line_dp` and `line_dm`. It then undoes the NRZI coding, waits for the start-of-packet SYNC pattern, removes stuffed bits and packs the remaining bits into bytes, least significant bit first.

`rx_active` is high for the whole packet. It rises once the SYNC pattern is complete and falls when the packet ends, either on an end-of-packet SE0 or on a line error. Each assembled byte is marked by a one-cycle `rx_valid` pulse. The pulse comes whenever eight kept bits have built up, not on a fixed cadence. `rx_data` keeps the byte until the next pulse, so the consumer may read it at any time during the byte period.

The byte output has no ready signal. The line cannot be stalled, so there is no back-pressure, and the consumer must take every `rx_valid` pulse in the cycle it appears. The recovery stage may place strobes at any spacing of one cycle or more. This covers nominal spacing, bit periods that stretch or shrink by a cycle to absorb a clock offset of around 1000 ppm, and back-to-back strobes. All control and status pins are plain levels or pulses.

Top module: `fs_rx_framer`

## Requirements
- R1: While `rst_n` is low, `rx_active`, `rx_valid` and `rx_error` are 0 and `rx_data` is all zeros.
- R2: Line levels are sampled only in cycles with `bit_stb` high. `line_dp`=1 means J (level 1) and `line_dp`=0 with `line_dm`=1 means K (level 0). Both low is SE0, and both high counts as J. A decoded bit is 1 when the level equals the previous bit's level and 0 when it changed. After an SE0 the previous level is taken as J.
- R3: While no packet is open, the block looks for the last eight levels K,J,K,J,K,J,K,K with no SE0 in between. `rx_active` rises two clock edges after the edge that samples the final K, and no SYNC bit is delivered as data.
- R4: `rx_active` changes only when a packet starts (R3) or ends (R8, R9, R10). Each change comes two edges after a strobed sample.
- R5: Kept data bits fill each byte from bit 0 upward. When the eighth kept bit is sampled, `rx_valid` is high for exactly one cycle, two edges after that sample, and only while `rx_active` is high.
- R6: `rx_data` changes only in the cycle in which `rx_valid` is high, and holds its last byte after the packet ends.
- R7: After six decoded ones in a row, the next bit is dropped as a stuffed bit. The final decoded one of SYNC counts toward this run.
- R8: If the bit in a stuffed position is a 1, `rx_error` pulses for one cycle, the packet ends in that same cycle, and the partly built byte is dropped.
- R9: One SE0 sample inside a packet ends it. `rx_active` falls, and any partly built byte is dropped without an `rx_valid` pulse.
- R10: If the line holds one level for more than seven bit times inside a packet (seven decoded ones in a row, counting the SYNC's final one), `rx_error` pulses and the packet ends. With default parameters this falls on the same sample as R8.
- R11: Strobe spacing may be any whole number of cycles of one or more and may vary from bit to bit. The byte stream is the same for every spacing.
- R12: While no packet is open, SE0 samples and level sequences other than the complete SYNC pattern raise neither `rx_active`, `rx_valid` nor `rx_error`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | Recovered bit is ready; line levels are sampled this cycle |
| line_dp | input | 1 | Positive line level |
| line_dm | input | 1 | Negative line level |
| rx_active | output | 1 | High for the duration of a received packet |
| rx_valid | output | 1 | One-cycle pulse per assembled byte |
| rx_data | output | BYTE_W | Last assembled byte, least significant bit received first |
| rx_error | output | 1 | One-cycle pulse when a packet is cut short by a line error |

## Verification
The bench targets the stuffing boundary with bytes whose ones carry across byte edges and that begin right after the SYNC's trailing one. A framer that ignored that seed one, or that dropped the wrong bit, would shift the following bytes or miss a stuffed position. Partial SYNC sequences and stray SE0 samples before a packet would start a false packet in a design that matched too few levels. A packet cut by SE0 partway through a byte, and one cut by an unstuffed run of ones, check that no partial byte leaks out and that `rx_data` keeps the last good byte. Back-to-back strobes and jittered spacing catch designs that assume a fixed byte period.

// File: rtl/fsrx_pkg.sv
package fsrx_pkg;

  typedef enum logic {ST_HUNT, ST_DATA} fsrx_state_e;

  localparam int SYNC_LEN = 8;
  // oldest level in the MSB, J = 1, K = 0 : K J K J K J K K
  localparam logic [SYNC_LEN-1:0] SYNC_LEVELS = 8'b0101_0100;

  typedef struct packed {
    logic vld;   // a strobed sample was taken
    logic se0;   // sample was single-ended zero
    logic lvl;   // differential level (J = 1)
    logic nrzi;  // decoded bit, 1 = no transition
  } line_sym_t;

endpackage

// File: rtl/fsrx_line_decode.sv
module fsrx_line_decode
  import fsrx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bit_stb,
  input  logic      line_dp,
  input  logic      line_dm,
  output line_sym_t sym_o
);

  logic prev_lvl;
  logic se0_now;

  assign se0_now = ~line_dp & ~line_dm;

  // R2: sample only on strobes, NRZI decode against the previous level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_o    <= '0;
      prev_lvl <= 1'b1;
    end else begin
      sym_o.vld <= bit_stb;
      if (bit_stb) begin
        sym_o.se0  <= se0_now;
        sym_o.lvl  <= se0_now ? 1'b1 : line_dp;
        sym_o.nrzi <= se0_now ? 1'b0 : (line_dp == prev_lvl);
        prev_lvl   <= se0_now ? 1'b1 : line_dp;
      end
    end
  end

endmodule

// File: rtl/fsrx_sync_hunt.sv
module fsrx_sync_hunt
  import fsrx_pkg::*;
#(
  parameter int                LEN     = SYNC_LEN,
  parameter logic [LEN-1:0]    PATTERN = SYNC_LEVELS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hunt_en,
  input  logic sym_vld,
  input  logic sym_se0,
  input  logic sym_lvl,
  output logic hit
);

  logic [LEN-1:0] hist;
  logic [LEN-1:0] hist_nxt;

  assign hist_nxt = {hist[LEN-2:0], sym_lvl};

  // R3 / R12: full pattern match only while hunting, SE0 breaks it
  assign hit = hunt_en & sym_vld & ~sym_se0 & (hist_nxt == PATTERN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '1;
    end else if (!hunt_en || (sym_vld && sym_se0)) begin
      hist <= '1;
    end else if (sym_vld) begin
      hist <= hist_nxt;
    end
  end

endmodule

// File: rtl/fsrx_destuff.sv
module fsrx_destuff #(
  parameter int RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seed,
  input  logic in_vld,
  input  logic in_bit,
  output logic out_vld,
  output logic stuff_err
);

  localparam int CW = $clog2(RUN + 1);

  logic [CW-1:0] ones;
  logic          at_limit;

  assign at_limit  = (ones == CW'(RUN));
  // R7: the bit after a full run is dropped; R8: it must be a zero
  assign out_vld   = in_vld & ~at_limit;
  assign stuff_err = in_vld & at_limit & in_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones <= '0;
    end else if (seed) begin
      ones <= CW'(1);
    end else if (in_vld) begin
      if (at_limit || !in_bit) ones <= '0;
      else                     ones <= ones + 1'b1;
    end
  end

endmodule

// File: rtl/fsrx_hold_guard.sv
module fsrx_hold_guard #(
  parameter int LIMIT = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seed,
  input  logic in_vld,
  input  logic in_bit,
  output logic hold_err
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] held;

  // R10: counts raw bit times without a transition, stuffed bits included
  assign hold_err = in_vld & in_bit & (held == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
    end else if (seed) begin
      held <= CW'(1);
    end else if (in_vld) begin
      if (!in_bit)                  held <= '0;
      else if (held != CW'(LIMIT))  held <= held + 1'b1;
    end
  end

endmodule

// File: rtl/fsrx_byte_pack.sv
module fsrx_byte_pack #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         in_vld,
  input  logic         in_bit,
  output logic         byte_vld,
  output logic [W-1:0] byte_data
);

  localparam int CW = $clog2(W);

  logic [W-1:0]  sr;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sr_nxt;

  // R5: first received bit ends up in bit 0
  assign sr_nxt = {in_bit, sr[W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '0;
      cnt       <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (clr) begin
        cnt <= '0;
      end else if (in_vld) begin
        sr <= sr_nxt;
        if (cnt == CW'(W - 1)) begin
          cnt       <= '0;
          byte_vld  <= 1'b1;
          byte_data <= sr_nxt;   // R6: held until the next completed byte
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fs_rx_framer.sv
module fs_rx_framer
  import fsrx_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int STUFF_RUN  = 6,
  parameter int HOLD_LIMIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              line_dp,
  input  logic              line_dm,
  output logic              rx_active,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_error
);

  fsrx_state_e state;
  line_sym_t   sym;
  logic        sync_hit;
  logic        data_vld;
  logic        eop;
  logic        kept_vld;
  logic        stuff_err;
  logic        hold_err;
  logic        abort;
  logic        err_q;

  fsrx_line_decode u_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_stb (bit_stb),
    .line_dp (line_dp),
    .line_dm (line_dm),
    .sym_o   (sym)
  );

  fsrx_sync_hunt u_hunt (
    .clk     (clk),
    .rst_n   (rst_n),
    .hunt_en (state == ST_HUNT),
    .sym_vld (sym.vld),
    .sym_se0 (sym.se0),
    .sym_lvl (sym.lvl),
    .hit     (sync_hit)
  );

  assign data_vld = (state == ST_DATA) & sym.vld & ~sym.se0;
  assign eop      = (state == ST_DATA) & sym.vld & sym.se0;   // R9

  fsrx_destuff #(.RUN(STUFF_RUN)) u_destuff (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed      (sync_hit),
    .in_vld    (data_vld),
    .in_bit    (sym.nrzi),
    .out_vld   (kept_vld),
    .stuff_err (stuff_err)
  );

  fsrx_hold_guard #(.LIMIT(HOLD_LIMIT)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed     (sync_hit),
    .in_vld   (data_vld),
    .in_bit   (sym.nrzi),
    .hold_err (hold_err)
  );

  assign abort = stuff_err | hold_err;

  fsrx_byte_pack #(.W(BYTE_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (sync_hit),
    .in_vld    (kept_vld & ~abort),
    .in_bit    (sym.nrzi),
    .byte_vld  (rx_valid),
    .byte_data (rx_data)
  );

  // R4: the packet state moves only on SYNC, SE0 or a line error
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HUNT;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (state)
        ST_HUNT: if (sync_hit) state <= ST_DATA;
        ST_DATA: begin
          if (eop) begin
            state <= ST_HUNT;
          end else if (abort) begin
            state <= ST_HUNT;
            err_q <= 1'b1;
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  assign rx_active = (state == ST_DATA);
  assign rx_error  = err_q;

endmodule

// File: rtl/fs_rx_framer_checker.sv
module fs_rx_framer_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bit_stb,
  input logic         rx_active,
  input logic         rx_valid,
  input logic         rx_error,
  input logic [W-1:0] rx_data
);

  assert_valid_in_packet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_active);

  assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data));

  assert_error_ends_packet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_error |-> (!rx_active && $past(rx_active)));

  assert_error_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_error |=> !rx_error);

  assert_active_after_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active != $past(rx_active)) |-> $past(bit_stb, 2));

  assert_no_byte_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active) |-> !rx_valid);

endmodule

bind fs_rx_framer fs_rx_framer_checker #(.W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_stb   (bit_stb),
  .rx_active (rx_active),
  .rx_valid  (rx_valid),
  .rx_error  (rx_error),
  .rx_data   (rx_data)
);

// File: tb/fs_rx_framer_bench.sv
`timescale 1ns/1ps
module fs_rx_framer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_stb = 1'b0;
  logic       line_dp = 1'b1;
  logic       line_dm = 1'b0;
  logic       rx_active;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_error;

  fs_rx_framer u_fs_rx_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .line_dp   (line_dp),
    .line_dm   (line_dm),
    .rx_active (rx_active),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_error  (rx_error)
  );

  always #2 clk = ~clk;

  int         checks = 0;
  int         failures = 0;
  logic [7:0] exp_q[$];
  logic [7:0] mon_exp;
  int         valid_seen = 0;
  int         err_seen = 0;
  int         rise_seen = 0;
  logic       prev_act = 1'b0;
  int         gap = 5;
  bit         jitter = 1'b0;
  int         jit_idx = 0;
  bit         cur_lvl = 1'b1;
  int         ones = 0;
  int         cyc = 0;
  int         base_valid;
  int         base_err;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        valid_seen++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected byte", int'(rx_data), 0);
        end else begin
          mon_exp = exp_q.pop_front();
          chk(rx_data == mon_exp, "R5", "byte value", int'(rx_data), int'(mon_exp));
        end
      end
      if (rx_error) err_seen++;
      if (rx_active && !prev_act) rise_seen++;
      prev_act = rx_active;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      failures++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // driver: one line sample, called at a negedge
  task automatic send_level(input bit dp, input bit dm);
    int g;
    g = jitter ? (4 + (jit_idx % 3)) : gap;
    jit_idx++;
    line_dp = dp;
    line_dm = dm;
    bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
    repeat (g - 1) @(negedge clk);
  endtask

  task automatic send_lvl(input bit l);
    cur_lvl = l;
    send_level(l, ~l);
  endtask

  task automatic send_nrzi(input bit b);
    if (!b) cur_lvl = ~cur_lvl;
    send_lvl(cur_lvl);
  endtask

  task automatic send_data_bit(input bit b);
    send_nrzi(b);
    if (b) ones++;
    else   ones = 0;
    if (ones == 6) begin
      send_nrzi(1'b0);
      ones = 0;
    end
  endtask

  task automatic send_sync_head();
    send_lvl(1'b0); send_lvl(1'b1); send_lvl(1'b0); send_lvl(1'b1);
    send_lvl(1'b0); send_lvl(1'b1); send_lvl(1'b0);
  endtask

  task automatic send_sync();
    send_sync_head();
    send_lvl(1'b0);
    ones = 1;
  endtask

  task automatic send_byte(input logic [7:0] b);
    exp_q.push_back(b);
    for (int i = 0; i < 8; i++) send_data_bit(b[i]);
  endtask

  task automatic send_eop();
    send_level(1'b0, 1'b0);
    send_level(1'b0, 1'b0);
    send_lvl(1'b1);
    ones = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send_lvl(1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rx_active == 1'b0 && rx_valid == 1'b0 && rx_error == 1'b0,
        "R1", "reset controls", {rx_active, rx_valid, rx_error}, 0);
    chk(rx_data == 8'h00, "R1", "reset data", int'(rx_data), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: stray SE0 and an incomplete SYNC while hunting
    idle(4);
    send_level(1'b0, 1'b0);
    send_lvl(1'b0); send_lvl(1'b1); send_lvl(1'b0); send_lvl(1'b1);
    send_lvl(1'b0); send_lvl(1'b1); send_lvl(1'b1); send_lvl(1'b1);
    send_sync_head();
    send_level(1'b0, 1'b0);
    idle(3);
    chk(rise_seen == 0 && rx_active == 1'b0, "R12", "no false packet", rise_seen, 0);
    chk(valid_seen == 0 && err_seen == 0, "R12", "no output while hunting",
        valid_seen + err_seen, 0);

    // R3: SYNC recognised only on its last K
    idle(3);
    send_sync_head();
    chk(rx_active == 1'b0, "R3", "active before last K", rx_active, 0);
    send_lvl(1'b0);
    ones = 1;
    chk(rx_active == 1'b1, "R3", "active after SYNC", rx_active, 1);
    chk(valid_seen == 0, "R3", "no SYNC data", valid_seen, 0);
    send_byte(8'hA5);
    send_byte(8'h3C);
    send_eop();
    chk(rx_active == 1'b0, "R9", "SE0 ends packet", rx_active, 0);
    chk(exp_q.size() == 0 && valid_seen == 2, "R2", "NRZI bytes delivered", valid_seen, 2);
    idle(3);
    chk(rx_data == 8'h3C, "R6", "data held after packet", int'(rx_data), 8'h3C);

    // R7: stuffing across bytes, including right after SYNC
    idle(2);
    send_sync();
    send_byte(8'hFF);
    send_byte(8'h7E);
    send_byte(8'h3F);
    send_byte(8'hFC);
    send_eop();
    chk(exp_q.size() == 0, "R7", "stuffed bytes all received", exp_q.size(), 0);
    chk(err_seen == 0, "R7", "no error on legal stuffing", err_seen, 0);

    // R11: back-to-back strobes
    gap = 1;
    idle(2);
    send_sync();
    send_byte(8'h00);
    send_byte(8'h80);
    send_byte(8'h01);
    send_byte(8'hFF);
    send_eop();
    chk(exp_q.size() == 0 && valid_seen == 10, "R11", "every-cycle strobes",
        valid_seen, 10);

    // R11: jittered spacing
    gap = 5;
    jitter = 1'b1;
    idle(2);
    send_sync();
    send_byte(8'h5A);
    send_byte(8'hC3);
    send_eop();
    jitter = 1'b0;
    chk(exp_q.size() == 0 && valid_seen == 12, "R11", "jittered strobes", valid_seen, 12);

    // R9: SE0 in the middle of a byte
    idle(2);
    send_sync();
    send_byte(8'h96);
    send_data_bit(1'b1);
    send_data_bit(1'b0);
    send_data_bit(1'b1);
    send_eop();
    idle(2);
    chk(valid_seen == 13 && exp_q.size() == 0, "R9", "partial byte dropped",
        valid_seen, 13);
    chk(rx_data == 8'h96, "R6", "data kept after partial", int'(rx_data), 8'h96);

    // R8 / R10: unstuffed run of ones
    idle(2);
    send_sync();
    send_byte(8'h11);
    base_valid = valid_seen;
    base_err = err_seen;
    for (int i = 0; i < 6; i++) send_nrzi(1'b1);
    chk(rx_active == 1'b1 && err_seen == base_err, "R8", "six ones still legal",
        err_seen - base_err, 0);
    send_nrzi(1'b1);
    chk(err_seen == base_err + 1, "R8", "stuff error pulse", err_seen - base_err, 1);
    chk(rx_active == 1'b0, "R10", "long hold ends packet", rx_active, 0);
    idle(8);
    chk(err_seen == base_err + 1 && valid_seen == base_valid, "R10",
        "single error, no partial byte", err_seen - base_err, 1);
    send_eop();

    // R4: recovery and packet count
    idle(2);
    send_sync();
    send_byte(8'h42);
    send_eop();
    chk(exp_q.size() == 0 && rx_data == 8'h42, "R5", "packet after error",
        int'(rx_data), 8'h42);
    chk(rise_seen == 7, "R4", "one rise per packet", rise_seen, 7);
    chk(rx_active == 1'b0, "R4", "idle after last packet", rx_active, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule